// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block runs a short, software-built program of NAND bus operations. Software writes an instruction word made of eight 4-bit opcodes. It also sets up a word of four command bytes, the column, row and user address values, a transfer byte count, a data-width select and a small data register. A single start strobe then launches the program. The sequencer reads the opcodes one at a time and drives the flash pins: command latch, address latch, write strobe, read strobe and the 8-bit data bus. It also watches the ready/busy line. Page data moves between the pins and an internal byte buffer, which software fills and reads through a separate port while the sequencer is idle.

Opcodes either issue command or address cycles, stream bytes to or from the buffer or data register, or first wait for the flash to report ready and then issue a command or a buffered read. A page read, for example, is one command, the column and row cycles, a second command, a ready wait and then the data read. All of that fits in a single instruction word. The buffer pointer keeps its value from one launch to the next. One large transfer can therefore be split across consecutive launches without reissuing the flash command.

The controller is a state machine with eight states. IDLE waits for start. DECODE examines the current opcode slot. WAIT_RDY holds until the synchronised ready line is high. WE_LO and WE_HI form one write-strobe pulse. RE_LO and RE_HI form one read-strobe pulse. FINISH raises the completion pulse.

The transitions are as follows:
- IDLE→DECODE on start.
- DECODE→FINISH on an end opcode.
- DECODE→DECODE or FINISH when an opcode has zero bytes to move.
- DECODE→WE_LO, RE_LO or WAIT_RDY for a working opcode.
- WAIT_RDY→WE_LO or RE_LO on ready.
- WE_LO→WE_HI and RE_LO→RE_HI after the low time.
- WE_HI→WE_LO and RE_HI→RE_LO for the next byte of an opcode.
- WE_HI or RE_HI→DECODE after the last byte, or →FINISH after slot 7.
- FINISH→IDLE.

Top module: `nand_seq_top`

## Requirements
- R1: Opcode slot k occupies bits 31-4k down to 28-4k of the instruction word. Slot 0 (bits 31:28) runs first and slot 7 (bits 3:0) runs last. After slot 7 the program ends even without an end opcode.
- R2: Opcode 0x0 and opcode 0xF each end the program at once. No later slot is executed.
- R3: Opcodes 0x4, 0x5, 0x6 and 0x7 each send one command byte with CLE high. The byte is taken from cmd_bytes bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R4: Opcode 0x1 sends col_addr as two ALE cycles, low byte first. Opcode 0x2 sends row_addr as three ALE cycles, least significant byte first. Opcode 0x3 sends user_addr as one ALE cycle.
- R5: Opcode 0x8 writes byte_count bytes from the buffer to the data bus. It starts at the buffer pointer, advances the pointer once per byte and wraps at the buffer depth.
- R6: Opcode 0xA reads byte_count bytes from the data bus into the buffer, starting at the buffer pointer and advancing it. Software can then read those bytes back through the buffer port.
- R7: Opcode 0x9 writes data_wr and opcode 0xB reads into data_rd. Each moves one byte (bits 7:0) when wide_mode is 0, or two bytes (low byte first) when wide_mode is 1.
- R8: Opcodes 0xC and 0xD wait until the ready line is high and then send cmd_bytes bits 7:0 or 15:8. Opcode 0xE waits the same way and then performs the 0xA read. No strobe is driven while the flash reports busy.
- R9: The buffer pointer is not reset by a new launch. A second program continues the buffer transfer from where the first one stopped.
- R10: Each strobe pulse is low for 2 clocks and high for 2 clocks. CLE, ALE and the driven data stay stable while the write strobe is low. CLE and ALE are never high together. The two strobes are never low together, and the data bus is not driven while the read strobe is low.
- R11: busy rises on the clock after an idle start. done is a single-cycle pulse at the end of the program, and busy falls on the clock after done. A start while busy is ignored.
- R12: A transfer opcode (0x8, 0xA, 0xE) with byte_count 0 produces no strobe pulse and moves on to the next slot.
- R13: After reset, busy, done, CLE and ALE are low and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, taken only while idle |
| instr_word | input | 32 | Eight 4-bit opcodes, slot 0 in bits 31:28 |
| cmd_bytes | input | 32 | Four command bytes, command k in bits 8k+7:8k |
| col_addr | input | 16 | Column address |
| row_addr | input | 24 | Block and page address |
| user_addr | input | 8 | User address byte |
| byte_count | input | CNT_W | Bytes per buffer transfer opcode |
| wide_mode | input | 1 | 1 selects two-byte data register transfers |
| data_wr | input | 16 | Data register source for opcode 0x9 |
| data_rd | output | 16 | Data register filled by opcode 0xB |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle completion pulse |
| sw_buf_we | input | 1 | Software buffer write enable (idle only) |
| sw_buf_addr | input | BUF_AW | Software buffer address |
| sw_buf_wdata | input | 8 | Software buffer write data |
| sw_buf_rdata | output | 8 | Software buffer read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Data bus driven value |
| nand_io_oe | output | 1 | Data bus output enable |
| nand_io_in | input | 8 | Data bus sampled value |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The checker watches the pin discipline on every cycle: CLE and ALE never high together, the two strobes never low together, and the bus never driven during a read pulse. It also checks the minimum strobe low time, and that the latch lines and the data stay stable while the write strobe is low. On the control side it checks the single-cycle done pulse followed by idle, and that busy rises after an idle start.

Only the bench scenarios can show what goes onto the bus. This covers the slot order, the command and address byte order, buffer contents and pointer continuation across launches, pointer wrap, one-byte versus two-byte data transfers, that no strobe occurs during flash busy, and that a start issued during a running program has no effect. The bench checks these against a small flash model.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0, OP_CA  = 4'h1, OP_PA  = 4'h2, OP_UA  = 4'h3,
        OP_CM0 = 4'h4, OP_CM1 = 4'h5, OP_CM2 = 4'h6, OP_CM3 = 4'h7,
        OP_WB  = 4'h8, OP_WS  = 4'h9, OP_RB  = 4'hA, OP_RS  = 4'hB,
        OP_CW0 = 4'hC, OP_CW1 = 4'hD, OP_RBW = 4'hE, OP_RSV = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DECODE, ST_WAIT_RDY, ST_WE_LO,
        ST_WE_HI, ST_RE_LO, ST_RE_HI, ST_FINISH
    } state_e;

    // Byte source (write opcodes) or destination (read opcodes)
    typedef enum logic [2:0] {
        SRC_CMD, SRC_COL, SRC_ROW, SRC_USR, SRC_BUF, SRC_DREG
    } src_e;

endpackage

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int BUF_AW  = 4,
    parameter int CNT_W   = 8,
    parameter int LO_CLKS = 2,
    parameter int HI_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr_word,
    input  logic [31:0]       cmd_bytes,
    input  logic [15:0]       col_addr,
    input  logic [23:0]       row_addr,
    input  logic [7:0]        user_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              wide_mode,
    input  logic [15:0]       data_wr,
    input  logic              rb_ready,
    input  logic [7:0]        io_in,
    input  logic [7:0]        buf_rdata,
    output logic              busy,
    output logic              done,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [7:0]        io_out,
    output logic              io_oe,
    output logic [15:0]       data_rd,
    output logic [BUF_AW-1:0] buf_ptr,
    output logic              buf_we,
    output logic [7:0]        buf_wdata
);

    localparam int PH_MAX = (LO_CLKS > HI_CLKS) ? LO_CLKS : HI_CLKS;
    localparam int PHW    = $clog2(PH_MAX + 1);
    localparam logic [PHW-1:0] LO_LAST = PHW'(LO_CLKS - 1);
    localparam logic [PHW-1:0] HI_LAST = PHW'(HI_CLKS - 1);

    state_e             state;
    op_e                op_q;
    src_e               src;
    logic [31:0]        instr_q;
    logic [2:0]         slot;
    logic [1:0]         cmd_idx;
    logic [CNT_W-1:0]   bidx, blen;
    logic [PHW-1:0]     ph;
    logic [BUF_AW-1:0]  ptr;
    logic [15:0]        dreg_q;

    // decode of the current slot
    op_e                cur_op;
    src_e               dec_src;
    logic [CNT_W-1:0]   dec_len;
    logic [1:0]         dec_cidx;
    logic               dec_stop;
    state_e             dec_next;
    state_e             end_st;
    logic               last_byte;
    logic [CNT_W-1:0]   dreg_len;

    assign cur_op    = op_e'(instr_q[5'd31 - {slot, 2'b00} -: 4]);
    assign end_st    = (slot == 3'd7) ? ST_FINISH : ST_DECODE;
    assign last_byte = (bidx == blen - 1'b1);
    assign dreg_len  = wide_mode ? CNT_W'(2) : CNT_W'(1);

    always_comb begin
        dec_src  = SRC_CMD;
        dec_len  = CNT_W'(1);
        dec_cidx = 2'd0;
        dec_stop = 1'b0;
        dec_next = ST_WE_LO;
        unique case (cur_op)
            OP_NOP, OP_RSV: dec_stop = 1'b1;
            OP_CA:  begin dec_src = SRC_COL; dec_len = CNT_W'(2); end
            OP_PA:  begin dec_src = SRC_ROW; dec_len = CNT_W'(3); end
            OP_UA:  dec_src = SRC_USR;
            OP_CM0, OP_CM1, OP_CM2, OP_CM3: dec_cidx = cur_op[1:0];
            OP_WB:  begin dec_src = SRC_BUF;  dec_len = byte_count; end
            OP_WS:  begin dec_src = SRC_DREG; dec_len = dreg_len; end
            OP_RB:  begin dec_src = SRC_BUF;  dec_len = byte_count; dec_next = ST_RE_LO; end
            OP_RS:  begin dec_src = SRC_DREG; dec_len = dreg_len;   dec_next = ST_RE_LO; end
            OP_CW0, OP_CW1: begin dec_cidx = {1'b0, cur_op[0]}; dec_next = ST_WAIT_RDY; end
            OP_RBW: begin dec_src = SRC_BUF; dec_len = byte_count; dec_next = ST_WAIT_RDY; end
            default: dec_stop = 1'b1;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_NOP;
            src     <= SRC_CMD;
            instr_q <= '0;
            slot    <= '0;
            cmd_idx <= '0;
            bidx    <= '0;
            blen    <= '0;
            ph      <= '0;
            ptr     <= '0;
            dreg_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    instr_q <= instr_word;
                    slot    <= '0;
                    state   <= ST_DECODE;
                end
                ST_DECODE: begin
                    bidx    <= '0;
                    ph      <= '0;
                    op_q    <= cur_op;
                    src     <= dec_src;
                    blen    <= dec_len;
                    cmd_idx <= dec_cidx;
                    if (dec_stop) begin
                        state <= ST_FINISH;
                    end else if (dec_len == '0) begin
                        slot  <= slot + 3'd1;
                        state <= end_st;
                    end else begin
                        state <= dec_next;
                    end
                end
                ST_WAIT_RDY: if (rb_ready)
                    state <= (op_q == OP_RBW) ? ST_RE_LO : ST_WE_LO;
                ST_WE_LO, ST_RE_LO: begin
                    if (ph == LO_LAST) begin
                        ph    <= '0;
                        state <= (state == ST_WE_LO) ? ST_WE_HI : ST_RE_HI;
                        if (state == ST_RE_LO && src == SRC_DREG)
                            dreg_q[{bidx[0], 3'b000} +: 8] <= io_in;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_WE_HI, ST_RE_HI: begin
                    if (ph == HI_LAST) begin
                        ph <= '0;
                        if (src == SRC_BUF) ptr <= ptr + 1'b1;
                        if (last_byte) begin
                            slot  <= slot + 3'd1;
                            state <= end_st;
                        end else begin
                            bidx  <= bidx + 1'b1;
                            state <= (state == ST_WE_HI) ? ST_WE_LO : ST_RE_LO;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    logic we_phase;
    always_comb begin
        we_phase  = (state == ST_WE_LO) || (state == ST_WE_HI);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        we_n      = (state != ST_WE_LO);
        re_n      = (state != ST_RE_LO);
        io_oe     = we_phase;
        cle       = we_phase && (src == SRC_CMD);
        ale       = we_phase && (src == SRC_COL || src == SRC_ROW || src == SRC_USR);
        buf_we    = (state == ST_RE_LO) && (ph == LO_LAST) && (src == SRC_BUF);
        buf_wdata = io_in;
        buf_ptr   = ptr;
        data_rd   = dreg_q;
        unique case (src)
            SRC_CMD:  io_out = cmd_bytes[{cmd_idx, 3'b000} +: 8];
            SRC_COL:  io_out = col_addr[{bidx[0], 3'b000} +: 8];
            SRC_ROW:  io_out = row_addr[{bidx[1:0], 3'b000} +: 8];
            SRC_USR:  io_out = user_addr;
            SRC_BUF:  io_out = buf_rdata;
            SRC_DREG: io_out = data_wr[{bidx[0], 3'b000} +: 8];
            default:  io_out = 8'h00;
        endcase
    end

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top #(
    parameter int BUF_DEPTH = 16,
    parameter int CNT_W     = 8,
    parameter int LO_CLKS   = 2,
    parameter int HI_CLKS   = 2,
    localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr_word,
    input  logic [31:0]       cmd_bytes,
    input  logic [15:0]       col_addr,
    input  logic [23:0]       row_addr,
    input  logic [7:0]        user_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              wide_mode,
    input  logic [15:0]       data_wr,
    output logic [15:0]       data_rd,
    output logic              busy,
    output logic              done,
    input  logic              sw_buf_we,
    input  logic [BUF_AW-1:0] sw_buf_addr,
    input  logic [7:0]        sw_buf_wdata,
    output logic [7:0]        sw_buf_rdata,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    input  logic              nand_rb_n
);

    logic              rb_s1, rb_s2;
    logic [BUF_AW-1:0] seq_ptr;
    logic              seq_buf_we;
    logic [7:0]        seq_buf_wdata, seq_buf_rdata;
    logic              mem_we;
    logic [BUF_AW-1:0] mem_waddr;
    logic [7:0]        mem_wdata;

    // two-flop synchroniser for the ready/busy line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_s1 <= 1'b0;
            rb_s2 <= 1'b0;
        end else begin
            rb_s1 <= nand_rb_n;
            rb_s2 <= rb_s1;
        end
    end

    // sequencer owns the buffer write port while running
    assign mem_we    = seq_buf_we | (sw_buf_we & ~busy);
    assign mem_waddr = seq_buf_we ? seq_ptr : sw_buf_addr;
    assign mem_wdata = seq_buf_we ? seq_buf_wdata : sw_buf_wdata;

    nand_seq_buf #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) buf_i (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (seq_ptr),
        .rdata_a (seq_buf_rdata),
        .raddr_b (sw_buf_addr),
        .rdata_b (sw_buf_rdata)
    );

    nand_seq_fsm #(
        .BUF_AW(BUF_AW), .CNT_W(CNT_W), .LO_CLKS(LO_CLKS), .HI_CLKS(HI_CLKS)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .instr_word (instr_word),
        .cmd_bytes  (cmd_bytes),
        .col_addr   (col_addr),
        .row_addr   (row_addr),
        .user_addr  (user_addr),
        .byte_count (byte_count),
        .wide_mode  (wide_mode),
        .data_wr    (data_wr),
        .rb_ready   (rb_s2),
        .io_in      (nand_io_in),
        .buf_rdata  (seq_buf_rdata),
        .busy       (busy),
        .done       (done),
        .cle        (nand_cle),
        .ale        (nand_ale),
        .we_n       (nand_we_n),
        .re_n       (nand_re_n),
        .io_out     (nand_io_out),
        .io_oe      (nand_io_oe),
        .data_rd    (data_rd),
        .buf_ptr    (seq_ptr),
        .buf_we     (seq_buf_we),
        .buf_wdata  (seq_buf_wdata)
    );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic       io_oe,
    input logic [7:0] io_out
);

    // R10
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R10
    bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);

    // R10
    we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !we_n);

    // R10
    re_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |=> !re_n);

    // R10
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> ($stable(cle) && $stable(ale) && $stable(io_out)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R11
    done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind nand_seq_top nand_seq_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .cle    (nand_cle),
    .ale    (nand_ale),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .io_oe  (nand_io_oe),
    .io_out (nand_io_out)
);

// File: tb/nand_seq_top_tb_top.sv
`timescale 1ns/1ps
module nand_seq_top_tb_top;

    localparam int DEPTH = 16;
    localparam int BUSY_CLKS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] cmd_bytes = '0;
    logic [15:0] col_addr = '0;
    logic [23:0] row_addr = '0;
    logic [7:0]  user_addr = '0;
    logic [7:0]  byte_count = '0;
    logic        wide_mode = 1'b0;
    logic [15:0] data_wr = '0;
    logic [15:0] data_rd;
    logic        busy, done;
    logic        sw_buf_we = 1'b0;
    logic [3:0]  sw_buf_addr = '0;
    logic [7:0]  sw_buf_wdata = '0;
    logic [7:0]  sw_buf_rdata;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in;
    logic        nand_rb_n;

    always #4 clk = ~clk;

    nand_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
        .cmd_bytes(cmd_bytes), .col_addr(col_addr), .row_addr(row_addr),
        .user_addr(user_addr), .byte_count(byte_count), .wide_mode(wide_mode),
        .data_wr(data_wr), .data_rd(data_rd), .busy(busy), .done(done),
        .sw_buf_we(sw_buf_we), .sw_buf_addr(sw_buf_addr),
        .sw_buf_wdata(sw_buf_wdata), .sw_buf_rdata(sw_buf_rdata),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
    );

    // ---------------- flash model (evaluated at falling edge) ----------------
    logic [7:0] cmd_log [256];
    logic [7:0] adr_log [256];
    logic [7:0] wdt_log [256];
    int n_cmd = 0, n_adr = 0, n_wdt = 0, n_rd = 0, n_done = 0;
    int busy_left = 0, n_busy = 0, strobe_in_busy = 0, bad_width = 0;
    int we_lo_run = 0, we_hi_run = 100, re_lo_run = 0, re_hi_run = 100;
    logic prev_we = 1'b1, prev_re = 1'b1;

    initial begin
        nand_rb_n  = 1'b1;
        nand_io_in = 8'h00;
    end

    always @(negedge clk) begin
        if (done) n_done++;
        if (!nand_we_n && prev_we) begin
            if (!nand_rb_n) strobe_in_busy++;
            if (we_hi_run < 2) bad_width++;
        end
        if (!nand_re_n && prev_re) begin
            if (!nand_rb_n) strobe_in_busy++;
            if (re_hi_run < 2) bad_width++;
        end
        if (nand_we_n && !prev_we) begin
            if (we_lo_run != 2) bad_width++;
            if (nand_cle) begin
                cmd_log[n_cmd[7:0]] = nand_io_out; n_cmd++;
                if (nand_io_out == 8'h30 || nand_io_out == 8'h10) begin
                    busy_left = BUSY_CLKS; nand_rb_n = 1'b0; n_busy++;
                end
            end else if (nand_ale) begin
                adr_log[n_adr[7:0]] = nand_io_out; n_adr++;
            end else begin
                wdt_log[n_wdt[7:0]] = nand_io_out; n_wdt++;
            end
        end
        if (nand_re_n && !prev_re) begin
            if (re_lo_run != 2) bad_width++;
            n_rd++;
        end
        we_lo_run = nand_we_n ? 0 : we_lo_run + 1;
        we_hi_run = nand_we_n ? we_hi_run + 1 : 0;
        re_lo_run = nand_re_n ? 0 : re_lo_run + 1;
        re_hi_run = nand_re_n ? re_hi_run + 1 : 0;
        nand_io_in = nand_re_n ? 8'h00 : 8'hC0 + 8'(n_rd);
        if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) nand_rb_n = 1'b1;
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    // ---------------- bookkeeping ----------------
    int checks = 0, fails = 0;
    bit finished = 1'b0;
    int tb_ptr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] iw);
        @(negedge clk);
        instr_word = iw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sw_fill(input logic [7:0] base);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            sw_buf_we = 1'b1; sw_buf_addr = 4'(i); sw_buf_wdata = base + 8'(i);
        end
        @(negedge clk);
        sw_buf_we = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0, "R13", {busy, done}, 0);
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R13",
            {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);
    endtask

    task automatic t_page_read();
        int c0 = n_cmd, a0 = n_adr, r0 = n_rd, b0 = n_busy;
        cmd_bytes = 32'h1080_3000; col_addr = 16'h0123; row_addr = 24'h045678;
        byte_count = 8'd4; wide_mode = 1'b0;
        run(32'h4125_E000);
        chk(n_cmd - c0 == 2, "R1", n_cmd - c0, 2);
        chk(cmd_log[c0[7:0]] == 8'h00, "R3", cmd_log[c0[7:0]], 8'h00);
        chk(cmd_log[8'(c0 + 1)] == 8'h30, "R3", cmd_log[8'(c0 + 1)], 8'h30);
        chk(n_adr - a0 == 5, "R4", n_adr - a0, 5);
        chk({adr_log[8'(a0)], adr_log[8'(a0+1)]} == 16'h2301, "R4",
            {adr_log[8'(a0)], adr_log[8'(a0+1)]}, 16'h2301);
        chk({adr_log[8'(a0+2)], adr_log[8'(a0+3)], adr_log[8'(a0+4)]} == 24'h785604, "R4",
            {adr_log[8'(a0+2)], adr_log[8'(a0+3)], adr_log[8'(a0+4)]}, 24'h785604);
        chk(n_rd - r0 == 4, "R8", n_rd - r0, 4);
        chk(n_busy - b0 == 1 && strobe_in_busy == 0, "R8", strobe_in_busy, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sw_buf_addr = 4'(tb_ptr + i);
            #1;
            chk(sw_buf_rdata == 8'hC0 + 8'(r0 + i), "R6", sw_buf_rdata, 8'hC0 + 8'(r0 + i));
        end
        tb_ptr = (tb_ptr + 4) % DEPTH;
    endtask

    task automatic t_back_to_back();
        int w0, c0, r0;
        sw_fill(8'h10);
        cmd_bytes = 32'h1080_7000; byte_count = 8'd4; wide_mode = 1'b0;
        w0 = n_wdt;
        run(32'h6128_0000);
        c0 = n_cmd; r0 = n_rd;
        run(32'h87DB_0000);
        chk(n_wdt - w0 == 8, "R5", n_wdt - w0, 8);
        for (int i = 0; i < 8; i++)
            chk(wdt_log[8'(w0 + i)] == 8'h10 + 8'(tb_ptr + i), "R9",
                wdt_log[8'(w0 + i)], 8'h10 + 8'(tb_ptr + i));
        chk(cmd_log[8'(c0)] == 8'h10 && cmd_log[8'(c0+1)] == 8'h70, "R8",
            {cmd_log[8'(c0)], cmd_log[8'(c0+1)]}, 16'h1070);
        chk(strobe_in_busy == 0, "R8", strobe_in_busy, 0);
        chk(n_rd - r0 == 1 && data_rd[7:0] == 8'hC0 + 8'(r0), "R7",
            data_rd[7:0], 8'hC0 + 8'(r0));
        tb_ptr = (tb_ptr + 8) % DEPTH;
    endtask

    task automatic t_wrap();
        int w0 = n_wdt;
        sw_fill(8'h80);
        byte_count = 8'd6;
        run(32'h8000_0000);
        chk(n_wdt - w0 == 6, "R5", n_wdt - w0, 6);
        for (int i = 0; i < 6; i++)
            chk(wdt_log[8'(w0 + i)] == 8'h80 + 8'((tb_ptr + i) % DEPTH), "R5",
                wdt_log[8'(w0 + i)], 8'h80 + 8'((tb_ptr + i) % DEPTH));
        tb_ptr = (tb_ptr + 6) % DEPTH;
    endtask

    task automatic t_wide();
        int w0 = n_wdt, r0 = n_rd;
        wide_mode = 1'b1; data_wr = 16'hBEEF;
        run(32'h9B00_0000);
        chk(n_wdt - w0 == 2, "R7", n_wdt - w0, 2);
        chk({wdt_log[8'(w0+1)], wdt_log[8'(w0)]} == 16'hBEEF, "R7",
            {wdt_log[8'(w0+1)], wdt_log[8'(w0)]}, 16'hBEEF);
        chk(data_rd == {8'hC0 + 8'(r0 + 1), 8'hC0 + 8'(r0)}, "R7",
            data_rd, {8'hC0 + 8'(r0 + 1), 8'hC0 + 8'(r0)});
        wide_mode = 1'b0;
    endtask

    task automatic t_end_ops();
        int c0 = n_cmd, d0 = n_done;
        cmd_bytes = 32'h4433_2211;
        run(32'h4050_0000);
        chk(n_cmd - c0 == 1 && n_done - d0 == 1, "R2", n_cmd - c0, 1);
        c0 = n_cmd;
        run(32'h4F50_0000);
        chk(n_cmd - c0 == 1 && cmd_log[8'(c0)] == 8'h11, "R2", n_cmd - c0, 1);
    endtask

    task automatic t_all_slots();
        int c0 = n_cmd, a0 = n_adr;
        logic [7:0] exp_b [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h33, 8'h55, 8'h11, 8'h22};
        cmd_bytes = 32'h4433_2211; user_addr = 8'h55;
        run(32'h4567_6345);
        chk(n_cmd - c0 == 7 && n_adr - a0 == 1, "R1", n_cmd - c0, 7);
        c0 = c0; // slot order: commands then the user address in place
        for (int i = 0, k = 0; i < 8; i++) begin
            if (i == 5) chk(adr_log[8'(a0)] == exp_b[i], "R4", adr_log[8'(a0)], exp_b[i]);
            else begin
                chk(cmd_log[8'(c0 + k)] == exp_b[i], "R1", cmd_log[8'(c0 + k)], exp_b[i]);
                k++;
            end
        end
    endtask

    task automatic t_zero_count();
        int c0 = n_cmd, w0 = n_wdt, r0 = n_rd;
        byte_count = 8'd0;
        run(32'h8AE4_0000);
        chk(n_wdt == w0 && n_rd == r0, "R12", n_wdt - w0 + n_rd - r0, 0);
        chk(n_cmd - c0 == 1, "R12", n_cmd - c0, 1);
    endtask

    task automatic t_start_busy();
        int c0 = n_cmd, d0 = n_done;
        cmd_bytes = 32'h4433_2211;
        @(negedge clk);
        instr_word = 32'h4567_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", busy, 1);
        repeat (3) @(negedge clk);
        instr_word = 32'h7777_7777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R11", busy, 0);
        repeat (4) @(negedge clk);
        chk(n_cmd - c0 == 4 && n_done - d0 == 1, "R11", n_cmd - c0, 4);
        chk(cmd_log[8'(c0 + 3)] == 8'h44, "R3", cmd_log[8'(c0 + 3)], 8'h44);
        chk(bad_width == 0, "R10", bad_width, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_page_read();
        t_back_to_back();
        t_wrap();
        t_wide();
        t_end_ops();
        t_all_slots();
        t_zero_count();
        t_start_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule